// File: doc/BRIEF.md
# Input Level Detector with Dwell Hysteresis

This block watches a wideband converter sample stream and drives one control line for an external attenuator or gain stage. The line rises as soon as the sample magnitude reaches a programmable upper threshold. It falls only after the magnitude has stayed below a separate, lower threshold for a programmable number of consecutive clocks. Any return to or above the lower threshold during that wait aborts it, and a new wait starts from the beginning.

Alongside the line, the block picks one of two 5-bit scale codes from a packed 10-bit configuration word. A "loud" code is used while the line is active and a "quiet" code while it is inactive. The selection follows the line after a programmable delay of zero to seven clocks, so that the internal rescaling lines up with the latency of the external gain element and of the converter pipeline. The mantissa is 14-bit two's complement. Thresholds are unsigned 13-bit magnitudes.

Top module: `lvl_detect`

## Requirements
- R1: The line is active after any clock edge that samples a magnitude greater than or equal to the upper threshold.
- R2: While the line is active, a sample whose magnitude is greater than or equal to the lower threshold keeps it active.
- R3: While the line is inactive, a sample whose magnitude is below the upper threshold leaves it inactive, even when that sample is above the lower threshold.
- R4: With dwell setting D, the line falls at the edge that samples the N-th consecutive below-lower sample, where N = D for D >= 1 and N = 1 for D = 0.
- R5: A sample at or above the lower threshold during the countdown aborts it, and N further consecutive below-lower samples are then needed. A sample at or above the upper threshold on the edge where the countdown would end keeps the line active.
- R6: Magnitude is the absolute value of the mantissa. The code -8192 saturates to 8191.
- R7: The scale output equals bits 4:0 of the scale word (loud) when the delayed select is active, and bits 9:5 (quiet) when it is inactive.
- R8: The delayed select equals the line state from `sw_delay_i` edges earlier. A delay of 0 follows the line in the same cycle.
- R9: A low `rst_n` at a clock edge makes the line inactive, clears the countdown, clears the delay history and selects the quiet code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_i | input | 14 | Converter mantissa, two's complement |
| thr_hi_i | input | 13 | Upper magnitude threshold |
| thr_lo_i | input | 13 | Lower magnitude threshold (not above the upper one) |
| dwell_i | input | 16 | Number of consecutive below-lower samples before release |
| scale_word_i | input | 10 | Quiet code in bits 9:5, loud code in bits 4:0 |
| sw_delay_i | input | 3 | Select delay in clocks, 0 to 7 |
| gain_line_o | output | 1 | Gain-control line, active high |
| scale_code_o | output | 5 | Selected scale code |

## Verification
The countdown's terminal step and an upper-threshold crossing can land on the same edge. The bench provokes this with a dwell of two. One below-lower sample is followed by a sample above the upper threshold at exactly the edge where release would occur. The line must stay high, and a fresh full countdown is then needed. The delayed scale select can also switch back to loud while the line is already falling. The bench judges this by checking the scale code and the line on the same sample against hand-computed values.

// File: rtl/lvl_pkg.sv
// Package: shared widths and state encoding for the level detector.
// Assumes the mantissa is two's complement and thresholds are magnitudes.
package lvl_pkg;
    localparam int MANT_W = 14;
    localparam int MAG_W  = MANT_W - 1;
    localparam int SCL_W  = 5;
    localparam int CNT_W  = 16;
    localparam int MAX_DLY = 7;
    localparam int DLY_W  = $clog2(MAX_DLY + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_DWELL = 2'd2
    } lvl_state_e;
endpackage

// File: rtl/lvl_mag.sv
// Module: absolute value of a two's-complement mantissa.
// The most negative code cannot be represented as a positive value,
// so it saturates to the all-ones magnitude. Purely combinational.
module lvl_mag #(
    parameter int MANT_W = 14,
    localparam int MAG_W = MANT_W - 1
) (
    input  logic [MANT_W-1:0] smp_i,
    output logic [MAG_W-1:0]  mag_o
);
    localparam logic [MANT_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

    logic [MANT_W-1:0] neg_w;

    // Negation and saturation of the magnitude.
    always_comb begin
        neg_w = ~smp_i + 1'b1;
        if (!smp_i[MANT_W-1])
            mag_o = smp_i[MAG_W-1:0];
        else if (smp_i == MOST_NEG)
            mag_o = '1;
        else
            mag_o = neg_w[MAG_W-1:0];
    end
endmodule

// File: rtl/lvl_hyst.sv
// Module: hysteresis state machine with dwell countdown.
// Sets the line on an upper-threshold hit. From the active state, counts
// consecutive below-lower samples and releases after max(dwell,1) of them.
// A sample at or above the lower threshold aborts the count.
// Assumes thr_lo <= thr_hi and that dwell does not change mid-count.
module lvl_hyst #(
    parameter int MAG_W = 13,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [MAG_W-1:0] thr_hi_i,
    input  logic [MAG_W-1:0] thr_lo_i,
    input  logic [CNT_W-1:0] dwell_i,
    output logic             line_o
);
    import lvl_pkg::*;

    lvl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ge_hi, ge_lo;

    // Threshold comparisons.
    always_comb begin
        ge_hi = (mag_i >= thr_hi_i);
        ge_lo = (mag_i >= thr_lo_i);
    end

    // Next-state and countdown logic; the upper threshold wins every tie.
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (ge_hi) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (ge_hi || ge_lo) begin
                    state_d = ST_HELD;
                end else if (dwell_i <= CNT_W'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_DWELL;
                    cnt_d   = dwell_i - 1'b1;
                end
            end
            ST_DWELL: begin
                if (ge_hi || ge_lo) begin
                    state_d = ST_HELD;
                end else if (cnt_q <= CNT_W'(1)) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Line is active in every state except idle.
    assign line_o = (state_q != ST_IDLE);
endmodule

// File: rtl/lvl_scale_dly.sv
// Module: delays the line by a programmable number of clocks and picks
// the loud or quiet scale code from the packed word.
// Assumes the delay setting never exceeds MAX_DLY.
module lvl_scale_dly #(
    parameter int SCL_W   = 5,
    parameter int MAX_DLY = 7,
    localparam int DLY_W  = $clog2(MAX_DLY + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_i,
    input  logic [DLY_W-1:0]   dly_i,
    input  logic [2*SCL_W-1:0] word_i,
    output logic [SCL_W-1:0]   code_o
);
    logic [MAX_DLY-1:0] hist_q;
    logic               sel_w;

    // History shift register of past line states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q[0] <= line_i;
            for (int i = 1; i < MAX_DLY; i++)
                hist_q[i] <= hist_q[i-1];
        end
    end

    // Tap select and scale code mux.
    always_comb begin
        sel_w = line_i;
        for (int k = 1; k <= MAX_DLY; k++)
            if (int'(dly_i) == k) sel_w = hist_q[k-1];
        code_o = sel_w ? word_i[SCL_W-1:0] : word_i[2*SCL_W-1:SCL_W];
    end
endmodule

// File: rtl/lvl_detect.sv
// Module: top of the input level detector.
// Magnitude -> hysteresis machine -> delayed scale select.
// Assumes thr_lo_i <= thr_hi_i and steady configuration during a countdown.
module lvl_detect (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [13:0] smp_i,
    input  logic [12:0] thr_hi_i,
    input  logic [12:0] thr_lo_i,
    input  logic [15:0] dwell_i,
    input  logic [9:0]  scale_word_i,
    input  logic [2:0]  sw_delay_i,
    output logic        gain_line_o,
    output logic [4:0]  scale_code_o
);
    import lvl_pkg::*;

    logic [MAG_W-1:0] mag_w;

    lvl_mag #(.MANT_W(MANT_W)) u_mag (
        .smp_i (smp_i),
        .mag_o (mag_w)
    );

    lvl_hyst #(.MAG_W(MAG_W), .CNT_W(CNT_W)) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .mag_i    (mag_w),
        .thr_hi_i (thr_hi_i),
        .thr_lo_i (thr_lo_i),
        .dwell_i  (dwell_i),
        .line_o   (gain_line_o)
    );

    lvl_scale_dly #(.SCL_W(SCL_W), .MAX_DLY(MAX_DLY)) u_scl (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (gain_line_o),
        .dly_i  (sw_delay_i),
        .word_i (scale_word_i),
        .code_o (scale_code_o)
    );
endmodule

// File: rtl/lvl_detect_chk.sv
// Checker: temporal properties of the level detector, bound to the top.
module lvl_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [12:0] mag,
    input logic [12:0] thr_hi,
    input logic [12:0] thr_lo,
    input logic        line,
    input logic [9:0]  word,
    input logic [2:0]  dly,
    input logic [4:0]  code
);
    // R1: upper-threshold hit sets the line on the next edge.
    a_r1_upper_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mag >= thr_hi) |=> line);

    // R2: an active line holds while magnitude is at or above the lower threshold.
    a_r2_hold_above_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (line && mag >= thr_lo) |=> line);

    // R3: an inactive line stays inactive below the upper threshold.
    a_r3_no_rise_below_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!line && mag < thr_hi) |=> !line);

    // R7: the code is always one of the two packed fields.
    a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (code == word[4:0]) || (code == word[9:5]));

    // R8: with zero delay the code tracks the line in the same cycle.
    a_r8_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (dly == 3'd0) |-> (code == (line ? word[4:0] : word[9:5])));
endmodule

bind lvl_detect lvl_detect_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mag    (mag_w),
    .thr_hi (thr_hi_i),
    .thr_lo (thr_lo_i),
    .line   (gain_line_o),
    .word   (scale_word_i),
    .dly    (sw_delay_i),
    .code   (scale_code_o)
);

// File: tb/test_lvl_detect.sv
module test_lvl_detect;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 20;
    localparam logic [4:0] LOUD  = 5'd26;
    localparam logic [4:0] QUIET = 5'd3;

    // Stimulus: sample; expected line after the edge that samples it.
    // Config: upper 1000, lower 500, dwell 3, delay 0.
    localparam logic [13:0] VEC_SMP [NVEC] = '{
        14'd0, 14'd999, 14'd1000, 14'd700, 14'd499,
        14'd100, 14'd600, 14'd400, -14'sd400, -14'sd300,
        14'd800, -14'sd1000, 14'h2000, 14'd500, 14'd499,
        14'd499, 14'd1200, 14'd0, 14'd0, 14'd0 };
    localparam logic VEC_LINE [NVEC] = '{
        1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
        1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
        1'b1, 1'b1, 1'b1, 1'b1, 1'b0 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] smp = '0;
    logic [12:0] thr_hi = 13'd1000;
    logic [12:0] thr_lo = 13'd500;
    logic [15:0] dwell = 16'd3;
    logic [9:0]  word = {QUIET, LOUD};
    logic [2:0]  dly = 3'd0;
    logic        line;
    logic [4:0]  code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    lvl_detect i_lvl_detect (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .thr_hi_i(thr_hi),
        .thr_lo_i(thr_lo), .dwell_i(dwell), .scale_word_i(word),
        .sw_delay_i(dly), .gain_line_o(line), .scale_code_o(code));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive a sample before the edge, then sample outputs just after it.
    task automatic step(input logic [13:0] s);
        @(negedge clk);
        smp = s;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp = '0;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        do_reset();
        check("R9 line after reset", line, 0);
        check("R9 quiet after reset", code, QUIET);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 with delay 0
        for (int i = 0; i < NVEC; i++) begin
            step(VEC_SMP[i]);
            check("R1/R2/R3/R4/R5 line vector", line, VEC_LINE[i]);
            check("R7 scale vector", code, VEC_LINE[i] ? LOUD : QUIET);
        end

        // R5: upper hit on the terminal edge keeps the line, fresh count follows
        dwell = 16'd2;
        do_reset();
        step(14'd2000); check("R1 set", line, 1);
        step(14'd0);    check("R4 first below", line, 1);
        step(14'd2000); check("R5 upper on terminal edge", line, 1);
        step(14'd0);    check("R5 fresh count 1", line, 1);
        step(14'd0);    check("R5 fresh count 2 releases", line, 0);

        // R4: dwell 0 behaves as one sample
        dwell = 16'd0;
        step(14'd2000); check("R1 set again", line, 1);
        step(14'd10);   check("R4 dwell zero releases at once", line, 0);

        // R6: most negative code saturates
        thr_hi = 13'd8191;
        thr_lo = 13'd100;
        dwell = 16'd3;
        do_reset();
        step(14'd8190); check("R6 below full scale", line, 0);
        step(14'h2000); check("R6 saturated magnitude", line, 1);

        // R8: delay 4
        thr_hi = 13'd1000;
        thr_lo = 13'd500;
        dwell = 16'd1;
        dly = 3'd4;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            step(14'd2000);
            check("R8 delayed still quiet", code, QUIET);
        end
        step(14'd2000); check("R8 switch to loud after 4", code, LOUD);
        check("R1 line during delay test", line, 1);
        step(14'd0);    check("R4 release with dwell 1", line, 0);
        check("R8 still loud after release", code, LOUD);
        step(14'd0); step(14'd0);
        step(14'd0);    check("R8 loud 3 edges after release", code, LOUD);
        step(14'd0);    check("R8 quiet 4 edges after release", code, QUIET);

        // R9: reset while active clears line and history
        step(14'd2000);
        step(14'd2000); step(14'd2000); step(14'd2000); step(14'd2000);
        check("R8 loud before reset", code, LOUD);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R9 line cleared", line, 0);
        check("R9 quiet with history cleared", code, QUIET);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule